// File: doc/BRIEF.md
# SD Card SPI Byte Transceiver

This block is a byte-wide SPI master for a memory card operated in its SPI mode. A host drives it with single-cycle strobes: one loads the SCK divider, one queues a transmit byte, one pops a received byte, and one latches three control flags. Those flags are transceiver enable, leading-idle filter and free-running clock. Transmit and receive FIFOs decouple the host from the bit shifter, and status outputs report FIFO room, emptiness, received data and overrun.

For card power-up, the free-running clock flag toggles SCK while chip select stays high and MOSI stays high, so the host can supply the wake-up clocks the card needs. Once the transceiver is enabled it holds chip select low and moves bytes in SPI mode 0. When the transmit queue runs dry it sends all-ones filler so that reads can continue. The receive filter discards the idle bytes that a card returns before its first response byte. A synchronised card-detect input drives presence and change outputs, and a busy output shows ongoing activity.

Top module: `sdspi_xcvr`

## Requirements
- R1: After reset cs_n=1, mosi=1, sck=0, tx_empty=1, tx_room=1, rx_avail=0, rx_ovr=0, card_changed=0, card_busy=0, and the divider holds 255.
- R2: A div_wr pulse loads wr_data into the divider D; each SCK high and low phase then lasts D+1 clock cycles.
- R3: A ctrl_wr pulse latches xcvr_en_in, filt_in and freeclk_in together and clears rx_ovr and card_changed on the same edge.
- R4: With free-clock set and the transceiver idle, sck toggles while cs_n=1 and mosi=1. With free-clock clear and the transceiver idle, sck stays 0.
- R5: tx_wr queues wr_data even while the transceiver is disabled. tx_room falls when TX_DEPTH bytes are queued, a write while full is discarded, and tx_empty reports an empty queue.
- R6: While enabled, cs_n=0 and queued bytes go out MSB first on mosi in SPI mode 0: sck idles low, mosi changes only on falling sck, and miso is sampled on rising sck.
- R7: When the transmit queue is empty at a byte boundary during an enabled transfer, the byte sent is 0xFF.
- R8: Received bytes are assembled MSB first into the receive FIFO. rd_data shows the head, rx_avail is high while it holds data, and an rx_rd pulse makes the next byte visible in the following cycle.
- R9: With the filter armed by a ctrl_wr that has filt_in=1, received 0xFF bytes are dropped until the first non-0xFF byte. From that byte on, every byte is stored.
- R10: A byte received while the receive FIFO is full is dropped and sets rx_ovr, which stays set until reset or ctrl_wr. Filling the FIFO exactly does not set it.
- R11: Clearing the enable by ctrl_wr lets the byte in progress finish; cs_n then returns to 1.
- R12: card_present follows cd_raw through two flops (high at the second clock after cd_raw rises). card_changed sets one clock later on either edge of cd_raw.
- R13: card_busy is 1 while cs_n=0, or while the transmit queue is non-empty with the enable set. It is 0 while the enable is clear and the link is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Byte for the transmit queue or the divider |
| tx_wr | input | 1 | Queue wr_data for transmission |
| div_wr | input | 1 | Load wr_data into the SCK divider |
| ctrl_wr | input | 1 | Latch the three control flags and clear sticky flags |
| xcvr_en_in | input | 1 | Transceiver enable value for ctrl_wr |
| filt_in | input | 1 | Idle-byte filter arm value for ctrl_wr |
| freeclk_in | input | 1 | Free-running clock value for ctrl_wr |
| rx_rd | input | 1 | Pop the receive head |
| rd_data | output | 8 | Receive FIFO head byte |
| tx_room | output | 1 | Transmit queue can accept a byte |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_avail | output | 1 | Receive FIFO holds data |
| rx_ovr | output | 1 | Sticky receive overrun |
| card_present | output | 1 | Synchronised card-detect level |
| card_changed | output | 1 | Sticky card-detect change |
| card_busy | output | 1 | Transfer activity indicator |
| cs_n | output | 1 | Card chip select, active low |
| mosi | output | 1 | Serial data to card |
| miso | input | 1 | Serial data from card |
| sck | output | 1 | Serial clock |
| cd_raw | input | 1 | Asynchronous card-detect input, high when present |

## Verification
A wrong bit counter or shift direction shows up within one byte time as a corrupted byte captured by the slave model or read back from rd_data. A wrong divider shows up within the first SCK phase as a phase length that differs from D+1. A filter or overrun flag stuck in the wrong state appears as soon as the bench drains the receive FIFO, as a missing, extra or misordered byte, or as rx_ovr at the wrong level. A stop that ignores the enable, or that stops too early, becomes visible at the next byte boundary through the count of bytes on the wire and through cs_n. Card-detect faults appear within three clocks of the input edge.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef enum logic {ST_IDLE, ST_XFER} xstate_t;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam int         DIV_W     = 8;
endpackage

// File: rtl/sdx_fifo.sv
module sdx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CNT_MAX = AW'(DEPTH) == '0 ? (AW+1)'(DEPTH) : (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CNT_MAX);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = do_push ? bump(wptr_q) : wptr_q;
    rptr_d = do_pop  ? bump(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end
endmodule

// File: rtl/sdx_card.sv
module sdx_card (
  input  logic clk,
  input  logic rst_n,
  input  logic cd_raw,
  input  logic clr,
  output logic present,
  output logic changed
);
  logic s1_q, s2_q, s3_q, chg_q, chg_d;

  always_comb begin
    chg_d = chg_q;
    if (s2_q != s3_q) chg_d = 1'b1;
    if (clr)          chg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      s1_q  <= cd_raw;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      chg_q <= chg_d;
    end
  end

  assign present = s2_q;
  assign changed = chg_q;
endmodule

// File: rtl/sdx_engine.sv
module sdx_engine
  import sdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             en,
  input  logic             freeclk,
  input  logic             tx_avail,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             active
);
  xstate_t          st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bits_q, bits_d;
  logic [7:0]       txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic             sck_q, sck_d;
  logic             running, tick, start;

  always_comb begin
    running  = (st_q == ST_XFER) || freeclk;
    tick     = running && (cnt_q == div_val);
    start    = (st_q == ST_IDLE) && en && !sck_q;
    cnt_d    = (!running || tick || start) ? '0 : cnt_q + 1'b1;
    st_d     = st_q;
    sck_d    = sck_q;
    bits_d   = bits_q;
    txsh_d   = txsh_q;
    rxsh_d   = rxsh_q;
    tx_pop   = 1'b0;
    rx_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_XFER;
          tx_pop = tx_avail;
          txsh_d = tx_avail ? tx_byte : IDLE_BYTE;
          bits_d = '0;
        end else if (freeclk) begin
          if (tick) sck_d = ~sck_q;
        end else begin
          sck_d = 1'b0;
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d  = 1'b1;
            rxsh_d = {rxsh_q[6:0], miso};
          end else begin
            sck_d = 1'b0;
            if (bits_q == 3'd7) begin
              rx_valid = 1'b1;
              if (en) begin
                tx_pop = tx_avail;
                txsh_d = tx_avail ? tx_byte : IDLE_BYTE;
                bits_d = '0;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              bits_d = bits_q + 1'b1;
              txsh_d = {txsh_q[6:0], 1'b1};
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bits_q <= '0;
      txsh_q <= IDLE_BYTE;
      rxsh_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      sck_q  <= sck_d;
    end
  end

  assign rx_byte = rxsh_q;
  assign sck     = sck_q;
  assign active  = (st_q == ST_XFER);
  assign cs_n    = !active;
  assign mosi    = active ? txsh_q[7] : 1'b1;
endmodule

// File: rtl/sdspi_xcvr.sv
module sdspi_xcvr
  import sdx_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       tx_wr,
  input  logic       div_wr,
  input  logic       ctrl_wr,
  input  logic       xcvr_en_in,
  input  logic       filt_in,
  input  logic       freeclk_in,
  input  logic       rx_rd,
  output logic [7:0] rd_data,
  output logic       tx_room,
  output logic       tx_empty,
  output logic       rx_avail,
  output logic       rx_ovr,
  output logic       card_present,
  output logic       card_changed,
  output logic       card_busy,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso,
  output logic       sck,
  input  logic       cd_raw
);
  logic             en_q, en_d, filt_q, filt_d, freeclk_q, freeclk_d, ovr_q, ovr_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tx_full, tx_pop, rx_full, rx_empty, rx_push, keep;
  logic             rx_valid, active;
  logic [7:0]       tx_head, rx_byte;

  always_comb begin
    keep      = !(filt_q && (rx_byte == IDLE_BYTE));
    rx_push   = rx_valid && keep && !rx_full;
    div_d     = div_wr ? wr_data[DIV_W-1:0] : div_q;
    en_d      = en_q;
    freeclk_d = freeclk_q;
    filt_d    = filt_q;
    ovr_d     = ovr_q;
    if (rx_valid && (rx_byte != IDLE_BYTE)) filt_d = 1'b0;
    if (rx_valid && keep && rx_full)        ovr_d  = 1'b1;
    if (ctrl_wr) begin
      en_d      = xcvr_en_in;
      freeclk_d = freeclk_in;
      filt_d    = filt_in;
      ovr_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      freeclk_q <= 1'b0;
      filt_q    <= 1'b0;
      ovr_q     <= 1'b0;
      div_q     <= '1;
    end else begin
      en_q      <= en_d;
      freeclk_q <= freeclk_d;
      filt_q    <= filt_d;
      ovr_q     <= ovr_d;
      div_q     <= div_d;
    end
  end

  sdx_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(wr_data), .pop(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  sdx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte), .pop(rx_rd),
    .dout(rd_data), .full(rx_full), .empty(rx_empty)
  );

  sdx_engine u_eng (
    .clk(clk), .rst_n(rst_n), .div_val(div_q), .en(en_q), .freeclk(freeclk_q),
    .tx_avail(!tx_empty), .tx_byte(tx_head), .miso(miso), .tx_pop(tx_pop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .active(active)
  );

  sdx_card u_card (
    .clk(clk), .rst_n(rst_n), .cd_raw(cd_raw), .clr(ctrl_wr),
    .present(card_present), .changed(card_changed)
  );

  assign tx_room   = !tx_full;
  assign rx_avail  = !rx_empty;
  assign rx_ovr    = ovr_q;
  assign card_busy = active || (!tx_empty && en_q);
endmodule

// File: rtl/sdx_xcvr_chk.sv
module sdx_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic mosi,
  input logic sck,
  input logic card_busy,
  input logic rx_ovr,
  input logic card_changed,
  input logic ctrl_wr,
  input logic freeclk_q,
  input logic rx_full
);
  // R4: idle link holds MOSI high
  p_idle_mosi_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> mosi);

  // R4: with free clock off, an idle link parks SCK low
  p_sck_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !freeclk_q) |=> !sck);

  // R6: inside a selected stretch MOSI moves only with a falling SCK
  p_mosi_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sck));

  // R10: overrun only rises when the receive FIFO was full
  p_ovr_needs_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_full));

  // R13: selected link reports busy
  p_busy_when_sel_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> card_busy);

  // R3: control write clears both sticky flags
  p_ctrl_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!rx_ovr && !card_changed));
endmodule

bind sdspi_xcvr sdx_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi), .sck(sck),
  .card_busy(card_busy), .rx_ovr(rx_ovr), .card_changed(card_changed),
  .ctrl_wr(ctrl_wr), .freeclk_q(freeclk_q), .rx_full(rx_full)
);

// File: tb/sim_sdspi_xcvr.sv
`timescale 1ns/1ps
module sim_sdspi_xcvr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wr_data;
  logic       tx_wr, div_wr, ctrl_wr, xcvr_en_in, filt_in, freeclk_in, rx_rd;
  logic [7:0] rd_data;
  logic       tx_room, tx_empty, rx_avail, rx_ovr;
  logic       card_present, card_changed, card_busy;
  logic       cs_n, mosi, miso, sck, cd_raw;

  always #2.5 clk = ~clk;

  sdspi_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .tx_wr(tx_wr), .div_wr(div_wr),
    .ctrl_wr(ctrl_wr), .xcvr_en_in(xcvr_en_in), .filt_in(filt_in),
    .freeclk_in(freeclk_in), .rx_rd(rx_rd), .rd_data(rd_data), .tx_room(tx_room),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .rx_ovr(rx_ovr),
    .card_present(card_present), .card_changed(card_changed), .card_busy(card_busy),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .sck(sck), .cd_raw(cd_raw)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- card-side slave model ----------------
  logic [7:0] resp [16];
  logic [7:0] cap  [16];
  int         resp_n = 0;
  int         ri = 0;
  int         bi = 0;
  int         cap_n = 0;
  logic [7:0] sh = 8'h00;

  function automatic logic [7:0] rbyte(input int k);
    return (k < resp_n) ? resp[k] : 8'hFF;
  endfunction

  always @(posedge sck) begin
    if (!cs_n) begin
      sh = {sh[6:0], mosi};
      bi++;
      if (bi == 8) begin
        if (cap_n < 16) cap[cap_n] = sh;
        cap_n++;
        ri++;
        bi = 0;
      end
    end
  end

  always @(negedge cs_n or negedge sck) begin
    if (!cs_n) begin
      logic [7:0] t;
      t = rbyte(ri);
      miso = t[7 - bi];
    end
  end

  task automatic slave_clear();
    ri = 0; bi = 0; cap_n = 0; resp_n = 0;
  endtask

  // ---------------- host helpers ----------------
  task automatic ctrl(input logic en, input logic filt, input logic fc);
    @(negedge clk);
    xcvr_en_in = en; filt_in = filt; freeclk_in = fc; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(negedge clk);
    wr_data = b; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic set_div(input logic [7:0] d);
    @(negedge clk);
    wr_data = d; div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    chk(req, rx_avail, 1'b1);
    chk(req, rd_data, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_cap(input string req, input int n);
    int k = 0;
    while (cap_n < n && k < 20000) begin @(negedge clk); k++; end
    if (k >= 20000) chk({req, " timeout"}, cap_n, n);
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (!cs_n && k < 20000) begin @(negedge clk); k++; end
    if (k >= 20000) chk({req, " timeout"}, cs_n, 1);
  endtask

  task automatic measure_high(input string req, input int exp);
    int k = 0;
    int hi = 0;
    while (sck && k < 2000) begin @(negedge clk); k++; end
    while (!sck && k < 2000) begin @(negedge clk); k++; end
    while (sck && k < 2000) begin
      chk("R4 cs_n high in free clock", cs_n, 1'b1);
      chk("R4 mosi high in free clock", mosi, 1'b1);
      @(negedge clk); hi++; k++;
    end
    chk(req, hi, exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 mosi", mosi, 1'b1);
    chk("R1 sck", sck, 1'b0);
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 tx_room", tx_room, 1'b1);
    chk("R1 rx_avail", rx_avail, 1'b0);
    chk("R1 rx_ovr", rx_ovr, 1'b0);
    chk("R1 card_changed", card_changed, 1'b0);
    chk("R1 card_busy", card_busy, 1'b0);
    // R1 divider 255: free clock high phase is 256 cycles
    ctrl(1'b0, 1'b0, 1'b1);
    measure_high("R1 reset divider phase", 256);
    ctrl(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_freeclk();
    set_div(8'd3);
    ctrl(1'b0, 1'b0, 1'b1);
    measure_high("R2 half period D=3", 4);
    set_div(8'd1);
    measure_high("R2 half period D=1", 2);
    ctrl(1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      chk("R4 sck parked with free clock off", sck, 1'b0);
      @(negedge clk);
    end
    chk("R3 flags off keep link idle", cs_n, 1'b1);
  endtask

  task automatic t_txqueue();
    set_div(8'd3);
    slave_clear();
    resp[0] = 8'h11; resp[1] = 8'h22; resp[2] = 8'h33; resp[3] = 8'h44; resp_n = 4;
    put_tx(8'hA1); put_tx(8'hB2); put_tx(8'hC3);
    chk("R5 tx_room with room left", tx_room, 1'b1);
    put_tx(8'hD4);
    chk("R5 tx_room full", tx_room, 1'b0);
    chk("R5 tx_empty", tx_empty, 1'b0);
    put_tx(8'hE5);
    chk("R5 queued while disabled keeps cs_n high", cs_n, 1'b1);
    chk("R13 busy low while disabled", card_busy, 1'b0);
    ctrl(1'b1, 1'b0, 1'b0);
    chk("R13 busy with queue and enable", card_busy, 1'b1);
    begin
      int k = 0;
      while (!tx_empty && k < 20000) begin @(negedge clk); k++; end
    end
    chk("R6 cs_n low while enabled", cs_n, 1'b0);
    ctrl(1'b0, 1'b0, 1'b0);
    wait_idle("R11");
    chk("R5 write while full dropped: byte count", cap_n, 4);
    chk("R6 byte 0 MSB first", cap[0], 8'hA1);
    chk("R6 byte 1", cap[1], 8'hB2);
    chk("R6 byte 2", cap[2], 8'hC3);
    chk("R6 byte 3", cap[3], 8'hD4);
    chk("R10 exact fill no overrun", rx_ovr, 1'b0);
    pop_expect("R8 head 0", 8'h11);
    pop_expect("R8 head 1", 8'h22);
    pop_expect("R8 head 2", 8'h33);
    pop_expect("R8 head 3", 8'h44);
    chk("R8 rx_avail after drain", rx_avail, 1'b0);
  endtask

  task automatic t_filler_stop();
    slave_clear();
    resp[0] = 8'h81; resp_n = 1;
    ctrl(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    ctrl(1'b0, 1'b0, 1'b0);
    chk("R11 byte in progress continues", cs_n, 1'b0);
    wait_idle("R11");
    chk("R11 exactly one byte", cap_n, 1);
    chk("R7 filler byte", cap[0], 8'hFF);
    chk("R13 busy low after stop", card_busy, 1'b0);
    pop_expect("R8 received byte", 8'h81);
  endtask

  task automatic t_filter();
    slave_clear();
    resp[0] = 8'hFF; resp[1] = 8'hFF; resp[2] = 8'h42; resp[3] = 8'hFF; resp[4] = 8'h17;
    resp_n = 5;
    ctrl(1'b1, 1'b1, 1'b0);
    wait_cap("R9", 5);
    ctrl(1'b0, 1'b0, 1'b0);
    wait_idle("R9");
    chk("R9 byte count on wire", cap_n, 5);
    pop_expect("R9 first kept", 8'h42);
    pop_expect("R9 later FF kept", 8'hFF);
    pop_expect("R9 last kept", 8'h17);
    chk("R9 leading FF dropped", rx_avail, 1'b0);
  endtask

  task automatic t_overrun();
    slave_clear();
    for (int i = 0; i < 6; i++) resp[i] = 8'(i + 1);
    resp_n = 6;
    ctrl(1'b1, 1'b0, 1'b0);
    wait_cap("R10", 5);
    chk("R10 no overrun at exact fill", rx_ovr, 1'b0);
    wait_cap("R10", 6);
    chk("R10 overrun set", rx_ovr, 1'b1);
    ctrl(1'b0, 1'b0, 1'b0);
    chk("R3 ctrl write clears overrun", rx_ovr, 1'b0);
    wait_idle("R10");
    pop_expect("R10 kept 1", 8'h01);
    pop_expect("R10 kept 2", 8'h02);
    pop_expect("R10 kept 3", 8'h03);
    pop_expect("R10 kept 4", 8'h04);
    chk("R10 extra bytes dropped", rx_avail, 1'b0);
  endtask

  task automatic t_card();
    @(negedge clk);
    cd_raw = 1'b1;
    @(negedge clk);
    chk("R12 present after one clock", card_present, 1'b0);
    @(negedge clk);
    chk("R12 present after two clocks", card_present, 1'b1);
    chk("R12 changed not yet", card_changed, 1'b0);
    @(negedge clk);
    chk("R12 changed on rise", card_changed, 1'b1);
    ctrl(1'b0, 1'b0, 1'b0);
    chk("R3 ctrl write clears changed", card_changed, 1'b0);
    cd_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 present after removal", card_present, 1'b0);
    chk("R12 changed on fall", card_changed, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; wr_data = '0; tx_wr = 0; div_wr = 0; ctrl_wr = 0;
    xcvr_en_in = 0; filt_in = 0; freeclk_in = 0; rx_rd = 0; miso = 1'b1; cd_raw = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_freeclk();
    t_txqueue();
    t_filler_stop();
    t_filter();
    t_overrun();
    t_card();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule